// File: doc/BRIEF.md
# Dual Cascadable Down-Counter Timer

This block holds two 8-bit reloading down-counters behind a small register interface. Each counter counts edges of a shared count clock, which arrives as a one-cycle strobe `cnt_edge_i` marking each falling edge of that clock. In event mode a counter counts a separate event strobe instead. On underflow the counter reloads and sets a sticky interrupt flag. An interrupt request goes out for a timer when its flag, its enable and its priority all allow it against the CPU's current interrupt level. The two counters can be joined into one 16-bit counter. A toggle output follows the underflows of the selected timer.

Run and stop requests are written by software but take effect at the next count edge. The run bit reads back as set until the counter has really halted, so software can poll it to see when a stop has completed. Everything runs on the single system clock `clk`. The count clock and the event source are plain enable strobes. The register port is a plain single-cycle write strobe with a combinational read, with no handshake. None of the interfaces carry streamed data, so none of them uses valid/ready.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 0 (address 0 control, 1 timer-0 count, 2 timer-1 count, 3 interrupt register), and `irq_o` and `tout_o` are 0.
- R2: A write to address 1 (or 2) stores the reload value for timer 0 (or 1), and also loads it into the counter when that counter is halted. A running counter decrements once per count strobe. A strobe that finds the counter at 0 reloads it instead, so one period is reload+1 strobes.
- R3: In the interrupt register (address 3), bits 1:0 are the timer-1/timer-0 flags and are write-one-to-clear, and writing 0 leaves a flag unchanged. Bits 3:2 are the enables. Bits 5:4 hold timer-0 priority and bits 7:6 timer-1 priority. If an underflow and a clearing write meet in the same cycle, the flag stays set.
- R4: A timer's flag is set on its underflow whatever its enable and priority settings are.
- R5: `irq_o[i]` is 1 exactly when flag i is 1, enable i is 1 and priority i is greater than `cpu_lvl_i`.
- R6: In count-clock mode, a change of run bit i (control bit i) is applied only at the next `cnt_edge_i` strobe. The strobe that starts a counter does not decrement it.
- R7: After a stop is written, the counter decrements once more, on the strobe that applies the stop, and then holds. Until that strobe, the run bit reads back as 1.
- R8: With event mode set for timer i (control bit 3+i), timer i counts `evt_pulse_i` strobes, and its run/stop takes effect one system cycle after the write, with no count strobe needed.
- R9: With the cascade bit set (control bit 2), timer 0's run and clock source drive a 16-bit counter made of count 1 (high byte) and count 0 (low byte). The low byte borrows from 00 to FF. The full counter reloads from {reload1, reload0} on underflow and sets only flag 1. Flag 0 is never set in this mode.
- R10: An internal toggle flips on each underflow of the timer chosen by control bit 6 (0 = timer 0, 1 = timer 1). `tout_o` shows it only while control bit 5 is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_edge_i | input | 1 | One-cycle strobe per falling edge of the count clock |
| evt_pulse_i | input | 1 | One-cycle strobe per external event |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| cpu_lvl_i | input | 2 | Current CPU interrupt level |
| irq_o | output | 2 | Interrupt requests, one per timer |
| tout_o | output | 1 | Gated toggle output |

## Verification
The counting function is exercised three ways: an 8-bit reload count of a small value, a timer driven by event strobes, and a 16-bit cascade whose reload has a nonzero low byte. The 8-bit count pins down the reload+1 period. The event-mode run shows that the count strobe is not needed to start or stop. The cascade run separates a true borrow (low byte to FF) from a per-byte reload, and shows which flag fires. Stop sequences are placed between strobes, which separates applying a run change at the write from applying it at the strobe. Sweeping the CPU level across the priority exposes an off-by-one in the greater-than comparison.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CNT0 = 2'd1,
    A_CNT1 = 2'd2,
    A_IRQ  = 2'd3
  } addr_e;

  // control register, bit 0 at the bottom
  typedef struct packed {
    logic       tout_sel;  // bit 6
    logic       tout_en;   // bit 5
    logic [1:0] evt;       // bits 4:3
    logic       casc;      // bit 2
    logic [1:0] run;       // bits 1:0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_runsync.sv
module tmr_runsync (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  logic evt_mode,
  input  logic fall_edge,
  output logic act
);
  // count-clock mode: apply on the falling-edge strobe; event mode: at once
  always_ff @(posedge clk) begin
    if (!rst_n)                    act <= 1'b0;
    else if (evt_mode || fall_edge) act <= run_req;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rld_we,
  input  logic [CW-1:0] rld_wd,
  input  logic          load_ok,
  input  logic          tick,
  input  logic          wrap_full,
  output logic [CW-1:0] cnt,
  output logic          zero
);
  logic [CW-1:0] rld_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      rld_q <= '0;
    else if (rld_we) rld_q <= rld_wd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (tick) begin
      if (cnt == '0) cnt <= wrap_full ? '1 : rld_q;
      else           cnt <= cnt - 1'b1;
    end else if (rld_we && load_ok) begin
      cnt <= rld_wd;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N  = 2,
  parameter int PW = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           set,
  input  logic [N-1:0]           clr,
  input  logic [N-1:0]           en,
  input  logic [N-1:0][PW-1:0]   prio,
  input  logic [PW-1:0]          lvl,
  output logic [N-1:0]           flag,
  output logic [N-1:0]           irq
);
  // an underflow in the same cycle as a clear keeps the flag
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= '0;
    else        flag <= (flag & ~clr) | set;
  end

  for (genvar i = 0; i < N; i++) begin : g_irq
    assign irq[i] = flag[i] & en[i] & (prio[i] > lvl);
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int CW = 8,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_edge_i,
  input  logic          evt_pulse_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  input  logic [PW-1:0] cpu_lvl_i,
  output logic [1:0]    irq_o,
  output logic          tout_o
);
  localparam int NT     = 2;
  localparam int EN_LSB = NT;
  localparam int PR_LSB = 2 * NT;

  ctrl_t                  ctrl_q;
  logic [NT-1:0]          en_q;
  logic [NT-1:0][PW-1:0]  prio_q;
  logic [NT-1:0]          flag;
  logic                   tout_q;

  logic wr_ctrl, wr_irq;
  logic [NT-1:0] src, act, tick, zero, wrap, busy, uf, rld_we, clr;
  logic [CW-1:0] cnt_q [NT];

  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_irq    = wr_en_i && (addr_i == A_IRQ);
  assign rld_we[0] = wr_en_i && (addr_i == A_CNT0);
  assign rld_we[1] = wr_en_i && (addr_i == A_CNT1);
  assign clr       = wr_irq ? wdata_i[NT-1:0] : '0;

  // ---------------- register file ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= '0;
      prio_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_irq) begin
        en_q <= wdata_i[EN_LSB +: NT];
        for (int i = 0; i < NT; i++) prio_q[i] <= wdata_i[PR_LSB + i*PW +: PW];
      end
    end
  end

  // ---------------- per-timer run sync and counter ----------------
  for (genvar i = 0; i < NT; i++) begin : g_tmr
    assign src[i] = ctrl_q.evt[i] ? evt_pulse_i : cnt_edge_i;

    tmr_runsync u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_req   (ctrl_q.run[i]),
      .evt_mode  (ctrl_q.evt[i]),
      .fall_edge (cnt_edge_i),
      .act       (act[i])
    );

    tmr_count #(.CW(CW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .rld_we    (rld_we[i]),
      .rld_wd    (wdata_i),
      .load_ok   (!busy[i]),
      .tick      (tick[i]),
      .wrap_full (wrap[i]),
      .cnt       (cnt_q[i]),
      .zero      (zero[i])
    );
  end

  // ---------------- cascade routing ----------------
  always_comb begin
    tick[0] = src[0] & act[0];
    tick[1] = ctrl_q.casc ? (src[0] & act[0] & zero[0]) : (src[1] & act[1]);
    wrap[0] = ctrl_q.casc & ~zero[1];
    wrap[1] = 1'b0;
    busy[0] = act[0];
    busy[1] = ctrl_q.casc ? act[0] : act[1];
    uf[0]   = src[0] & act[0] & zero[0] & ~ctrl_q.casc;
    uf[1]   = tick[1] & zero[1];
  end

  // ---------------- flags and requests ----------------
  tmr_flags #(.N(NT), .PW(PW)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (uf),
    .clr   (clr),
    .en    (en_q),
    .prio  (prio_q),
    .lvl   (cpu_lvl_i),
    .flag  (flag),
    .irq   (irq_o)
  );

  // ---------------- toggle output ----------------
  always_ff @(posedge clk) begin
    if (!rst_n)                   tout_q <= 1'b0;
    else if (uf[ctrl_q.tout_sel]) tout_q <= ~tout_q;
  end
  assign tout_o = tout_q & ctrl_q.tout_en;

  // ---------------- read mux ----------------
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[CTRL_W-1:0] = ctrl_q;
        rdata_o[NT-1:0]     = ctrl_q.run | act;
      end
      A_CNT0: rdata_o = cnt_q[0];
      A_CNT1: rdata_o = cnt_q[1];
      A_IRQ: begin
        rdata_o[NT-1:0]        = flag;
        rdata_o[EN_LSB +: NT]  = en_q;
        for (int i = 0; i < NT; i++) rdata_o[PR_LSB + i*PW +: PW] = prio_q[i];
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int CW = 8,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          casc,
  input logic          evt0,
  input logic          cnt_edge,
  input logic          act0,
  input logic [CW-1:0] cnt0,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic [CW-1:0] wdata,
  input logic [1:0]    flag,
  input logic          uf0,
  input logic [PW-1:0] prio0,
  input logic [PW-1:0] lvl,
  input logic [1:0]    irq,
  input logic          tout_en,
  input logic          tout
);
  a_r9_low_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && !flag[0]) |=> !flag[0]);

  a_r6_run_waits_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt0 && !cnt_edge) |=> $stable(act0));

  a_r7_halted_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!act0 && !(wr_en && addr == 2'd1)) |=> $stable(cnt0));

  a_r4_uf_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    uf0 |=> flag[0]);

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata[0] && !uf0) |=> !flag[0]);

  a_r5_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (prio0 <= lvl) |-> !irq[0]);

  a_r10_tout_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !tout_en |-> !tout);
endmodule

bind tmr_pair tmr_pair_chk #(.CW(CW), .PW(PW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .casc     (ctrl_q.casc),
  .evt0     (ctrl_q.evt[0]),
  .cnt_edge (cnt_edge_i),
  .act0     (act[0]),
  .cnt0     (cnt_q[0]),
  .wr_en    (wr_en_i),
  .addr     (addr_i),
  .wdata    (wdata_i),
  .flag     (flag),
  .uf0      (uf[0]),
  .prio0    (prio_q[0]),
  .lvl      (cpu_lvl_i),
  .irq      (irq_o),
  .tout_en  (ctrl_q.tout_en),
  .tout     (tout_o)
);

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_edge = 1'b0;
  logic       evt_pulse = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [1:0] lvl = 2'd0;
  logic [1:0] irq;
  logic       tout;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tmr_pair dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_edge_i  (cnt_edge),
    .evt_pulse_i (evt_pulse),
    .wr_en_i     (wr_en),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .cpu_lvl_i   (lvl),
    .irq_o       (irq),
    .tout_o      (tout)
  );

  task automatic check(string req, int actual, int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic edges(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cnt_edge = 1'b1;
      @(negedge clk); cnt_edge = 1'b0;
    end
  endtask

  task automatic evts(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt_pulse = 1'b1;
      @(negedge clk); evt_pulse = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 reg after reset", d, 0);
    end
    check("R1 irq after reset", irq, 0);
    check("R1 tout after reset", tout, 0);
  endtask

  task automatic t_count8();
    logic [7:0] d;
    wr(2'd1, 8'd3);
    rd(2'd1, d); check("R2 preset while halted", d, 3);
    wr(2'd0, 8'h01);
    rd(2'd1, d); check("R6 no count before edge", d, 3);
    edges(1);
    rd(2'd1, d); check("R6 start edge no decrement", d, 3);
    edges(3);
    rd(2'd1, d); check("R2 decrement to zero", d, 0);
    rd(2'd3, d); check("R2 no flag before underflow", d[0], 0);
    edges(1);
    rd(2'd1, d); check("R2 reload on underflow", d, 3);
    rd(2'd3, d); check("R4 flag set while disabled", d[0], 1);
    check("R4 no irq while disabled", irq[0], 0);
  endtask

  task automatic t_stop();
    logic [7:0] d;
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R7 run reads 1 until halted", d[0], 1);
    rd(2'd1, d); check("R6 stop not applied before edge", d, 3);
    edges(1);
    rd(2'd1, d); check("R7 one last decrement", d, 2);
    rd(2'd0, d); check("R7 run reads 0 after halt", d[0], 0);
    edges(2);
    rd(2'd1, d); check("R7 halted counter holds", d, 2);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    lvl = 2'd1;
    wr(2'd3, 8'h24);  // en0=1, prio0=2, no clear
    rd(2'd3, d); check("R3 zero write keeps flag", d[0], 1);
    check("R5 irq prio 2 over level 1", irq[0], 1);
    lvl = 2'd2; #1;
    check("R5 no irq prio equals level", irq[0], 0);
    lvl = 2'd3; #1;
    check("R5 no irq prio below level", irq[0], 0);
    lvl = 2'd0; #1;
    check("R5 irq prio over level 0", irq[0], 1);
    wr(2'd3, 8'h25);
    rd(2'd3, d); check("R3 one write clears flag", d[0], 0);
    check("R3 irq drops after clear", irq[0], 0);
  endtask

  task automatic t_event();
    logic [7:0] d;
    wr(2'd2, 8'd2);
    wr(2'd0, 8'h12);  // run1, evt1
    @(negedge clk);
    evts(1);
    rd(2'd2, d); check("R8 event start without count edge", d, 1);
    wr(2'd0, 8'h10);
    @(negedge clk);
    rd(2'd0, d); check("R8 event stop immediate", d[1], 0);
    evts(1);
    rd(2'd2, d); check("R8 no count after stop", d, 1);
  endtask

  task automatic t_tout();
    logic t0;
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h01);
    edges(2);
    check("R10 tout gated off", tout, 0);
    wr(2'd0, 8'h21);
    t0 = tout;
    edges(1);
    check("R10 tout toggles on underflow", tout, !t0);
    edges(1);
    check("R10 tout toggles back", tout, t0);
    wr(2'd0, 8'h61);  // select idle timer 1
    edges(1);
    check("R10 unselected timer no toggle", tout, t0);
    wr(2'd0, 8'h00);
    edges(1);
  endtask

  task automatic t_cascade();
    logic [7:0] d;
    wr(2'd3, 8'h03);  // clear flags
    wr(2'd0, 8'h04);
    wr(2'd1, 8'd1);
    wr(2'd2, 8'd1);
    wr(2'd0, 8'h05);
    edges(1);
    edges(2);
    rd(2'd1, d); check("R9 low byte borrows to FF", d, 8'hFF);
    rd(2'd2, d); check("R9 high byte after borrow", d, 0);
    edges(255);
    rd(2'd1, d); check("R9 low byte at zero", d, 0);
    rd(2'd3, d); check("R9 no flag before full underflow", d[1:0], 0);
    edges(1);
    rd(2'd1, d); check("R9 low reload", d, 1);
    rd(2'd2, d); check("R9 high reload", d, 1);
    rd(2'd3, d); check("R9 only upper flag set", d[1:0], 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count8();
    t_stop();
    t_irq();
    t_event();
    t_tout();
    t_cascade();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule